// File: doc/BRIEF.md
# Windowed Watchdog Timing Core

This block supervises a host processor through one trigger input. When enabled it starts with a generous long-open window. The host must deliver a qualified trigger pulse before that window runs out. Each accepted trigger then opens a close window, during which triggers are forbidden. After the close window comes an open window, during which the next trigger is expected. A trigger that is missing or arrives too early produces a single-cycle expiry event, and the core starts over from the long-open window. Reset pulse shaping, register storage and power sequencing belong to the surrounding logic and are not part of this core.

Time is counted in ticks of an external timebase strobe. `TICKS_PER_MS` sets how many ticks make one millisecond, and `MIN_PULSE_TICKS` sets the minimum trigger width. The trigger passes through a two-flop synchronizer. Its high time is counted in ticks, and it becomes a valid trigger at the tick on which it reaches the minimum width. A disable pin can switch the core off, but only when the disable-control input permits it. A lock input keeps the core running whatever the disable inputs say and freezes the window codes. A configuration-write strobe restarts the long-open window, except in stop mode or while locked.

Top module: `wdw_window_core`

## Requirements
- R1: While reset is asserted, `state_o` is 0 (off) and `expire_o` is 0. State codes are 0 off, 1 long-open, 2 close, 3 open.
- R2: On the first clock after the core is enabled in the off state, it enters long-open (1). The long-open window lasts 200, 600, 2000 or 5000 ms times `TICKS_PER_MS` ticks for `long_sel_i` codes 0, 1, 2, 3.
- R3: The close window lasts 10, 20, 50 or 100 ms worth of ticks for `close_sel_i` codes 0 to 3, and then the state moves to open (3). The open window lasts 20, 100, 200 or 600 ms worth of ticks for `open_sel_i` codes 0 to 3.
- R4: A valid trigger during long-open or open ends that window and starts a close window (2). A close window is entered only from long-open or open.
- R5: A valid trigger during a close window produces an expiry and restarts long-open.
- R6: A trigger whose high time spans fewer than `MIN_PULSE_TICKS` ticks is ignored.
- R7: When long-open or open runs its full length without a valid trigger, `expire_o` pulses and the state returns to long-open.
- R8: `cfg_wr_i` with `stop_i` low and `lock_i` low restarts long-open from its full length without an expiry. With `stop_i` high it has no effect.
- R9: With `lock_i` low, `dis_ctrl_i` and `dis_pin_i` both high put the core in the off state on the next clock. A high `dis_pin_i` has no effect when `dis_ctrl_i` is low. Re-enabling resumes from long-open.
- R10: While `lock_i` is high, the core is never switched off, `cfg_wr_i` has no effect, and the window codes seen at the moment of locking are used in place of the inputs.
- R11: Each window's length is taken from its code when the window starts. A code change during a window applies from the next window.
- R12: `expire_o` lasts exactly one clock per expiry and coincides with state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one clock wide |
| trig_i | input | 1 | Host trigger, asynchronous |
| long_sel_i | input | 2 | Long-open length code |
| close_sel_i | input | 2 | Close length code |
| open_sel_i | input | 2 | Open length code |
| lock_i | input | 1 | Settings lock, forces enable |
| dis_ctrl_i | input | 1 | Lets the disable pin act |
| dis_pin_i | input | 1 | Disable pin, high disables |
| cfg_wr_i | input | 1 | Configuration write strobe |
| stop_i | input | 1 | Stop mode indication |
| expire_o | output | 1 | Expiry event, one clock |
| state_o | output | 2 | Window state code |

## Verification
On every clock, the bound assertions check the following. An expiry is a single-clock event that coincides with long-open. Disabling gives the off state on the next clock. Enabling from off gives long-open. Lock keeps the core out of off. An unblocked configuration write restarts long-open. Close is entered only from long-open or open, and open only from close. Exact window lengths for each code, rejection of short pulses, sampling of codes at window start, and the code freeze under lock can only be shown by the bench. It measures the spacing between state changes in directed scenarios and compares every clock against its own reference model during randomized traffic.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [1:0] {
        WS_OFF   = 2'd0,
        WS_LONG  = 2'd1,
        WS_CLOSE = 2'd2,
        WS_OPEN  = 2'd3
    } wdw_state_e;

    typedef struct packed {
        logic [1:0] long_sel;
        logic [1:0] close_sel;
        logic [1:0] open_sel;
    } wdw_codes_t;

    function automatic int long_ms(logic [1:0] code);
        case (code)
            2'd0:    return 200;
            2'd1:    return 600;
            2'd2:    return 2000;
            default: return 5000;
        endcase
    endfunction

    function automatic int close_ms(logic [1:0] code);
        case (code)
            2'd0:    return 10;
            2'd1:    return 20;
            2'd2:    return 50;
            default: return 100;
        endcase
    endfunction

    function automatic int open_ms(logic [1:0] code);
        case (code)
            2'd0:    return 20;
            2'd1:    return 100;
            2'd2:    return 200;
            default: return 600;
        endcase
    endfunction

endpackage

// File: rtl/wdw_trig_qual.sv
module wdw_trig_qual #(
    parameter int MIN_PULSE_TICKS = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic trig_i,
    output logic valid_o
);
    localparam int WW = (MIN_PULSE_TICKS < 1) ? 1 : $clog2(MIN_PULSE_TICKS + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [WW-1:0] wcnt;
    } qual_t;

    qual_t q, d;

    always_comb begin
        d    = q;
        d.s1 = trig_i;
        d.s2 = q.s1;
        if (!q.s2) begin
            d.wcnt = '0;
        end else if (tick_i && (q.wcnt < WW'(MIN_PULSE_TICKS))) begin
            d.wcnt = q.wcnt + WW'(1);
        end
        valid_o = q.s2 && tick_i && (q.wcnt == WW'(MIN_PULSE_TICKS - 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/wdw_code_hold.sv
module wdw_code_hold
    import wdw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lock_i,
    input  wdw_codes_t codes_i,
    output wdw_codes_t codes_o
);
    wdw_codes_t held_q, held_d;

    always_comb begin
        held_d  = lock_i ? held_q : codes_i;
        codes_o = lock_i ? held_q : codes_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) held_q <= '0;
        else         held_q <= held_d;
    end
endmodule

// File: rtl/wdw_window_core.sv
module wdw_window_core
    import wdw_pkg::*;
#(
    parameter int TICKS_PER_MS    = 10,
    parameter int MIN_PULSE_TICKS = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       trig_i,
    input  logic [1:0] long_sel_i,
    input  logic [1:0] close_sel_i,
    input  logic [1:0] open_sel_i,
    input  logic       lock_i,
    input  logic       dis_ctrl_i,
    input  logic       dis_pin_i,
    input  logic       cfg_wr_i,
    input  logic       stop_i,
    output logic       expire_o,
    output logic [1:0] state_o
);
    localparam int MAX_TICKS = 5000 * TICKS_PER_MS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        wdw_state_e    state;
        logic [CW-1:0] rem;
        logic          expire;
    } core_t;

    core_t      q, d;
    logic       trig_ok;
    logic       enabled;
    wdw_codes_t codes_in, codes_eff;
    logic [CW-1:0] len_long, len_close, len_open;

    assign codes_in = '{long_sel: long_sel_i, close_sel: close_sel_i, open_sel: open_sel_i};

    wdw_trig_qual #(.MIN_PULSE_TICKS(MIN_PULSE_TICKS)) u_qual (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .trig_i  (trig_i),
        .valid_o (trig_ok)
    );

    wdw_code_hold u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lock_i  (lock_i),
        .codes_i (codes_in),
        .codes_o (codes_eff)
    );

    always_comb begin
        enabled   = lock_i || !(dis_ctrl_i && dis_pin_i);
        len_long  = CW'(long_ms(codes_eff.long_sel) * TICKS_PER_MS);
        len_close = CW'(close_ms(codes_eff.close_sel) * TICKS_PER_MS);
        len_open  = CW'(open_ms(codes_eff.open_sel) * TICKS_PER_MS);

        d        = q;
        d.expire = 1'b0;
        if (!enabled) begin
            d.state = WS_OFF;
            d.rem   = '0;
        end else if (q.state == WS_OFF) begin
            d.state = WS_LONG;
            d.rem   = len_long;
        end else if (cfg_wr_i && !stop_i && !lock_i) begin
            d.state = WS_LONG;
            d.rem   = len_long;
        end else if (trig_ok) begin
            if (q.state == WS_CLOSE) begin
                d.expire = 1'b1;
                d.state  = WS_LONG;
                d.rem    = len_long;
            end else begin
                d.state = WS_CLOSE;
                d.rem   = len_close;
            end
        end else if (tick_i) begin
            if (q.rem <= CW'(1)) begin
                if (q.state == WS_CLOSE) begin
                    d.state = WS_OPEN;
                    d.rem   = len_open;
                end else begin
                    d.expire = 1'b1;
                    d.state  = WS_LONG;
                    d.rem    = len_long;
                end
            end else begin
                d.rem = q.rem - CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state  <= WS_OFF;
            q.rem    <= '0;
            q.expire <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign expire_o = q.expire;
    assign state_o  = q.state;
endmodule

// File: rtl/wdw_window_core_chk.sv
module wdw_window_core_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       lock_i,
    input logic       dis_ctrl_i,
    input logic       dis_pin_i,
    input logic       cfg_wr_i,
    input logic       stop_i,
    input logic       expire_o,
    input logic [1:0] state_o
);
    logic en_chk;
    assign en_chk = lock_i || !(dis_ctrl_i && dis_pin_i);

    p_expire_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);

    p_expire_in_long_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |-> (state_o == 2'd1));

    p_disable_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lock_i && dis_ctrl_i && dis_pin_i) |=> (state_o == 2'd0));

    p_enable_long_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_o == 2'd0) && en_chk) |=> (state_o == 2'd1));

    p_lock_stays_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_i && (state_o != 2'd0)) |=> (state_o != 2'd0));

    p_cfg_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && !stop_i && !lock_i && en_chk && (state_o != 2'd0))
        |=> ((state_o == 2'd1) && !expire_o));

    p_close_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd0) |=> (state_o != 2'd2));

    p_open_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_o == 2'd0) || (state_o == 2'd1)) |=> (state_o != 2'd3));
endmodule

bind wdw_window_core wdw_window_core_chk u_chk (.*);

// File: tb/wdw_window_core_tb.sv
`timescale 1ns/1ps
module wdw_window_core_tb;
    localparam int TPM  = 1;
    localparam int MINP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, trig = 1'b0;
    logic [1:0] lsel = 2'd0, csel = 2'd0, osel = 2'd0;
    logic lock = 1'b0, dctl = 1'b0, dpin = 1'b0, cfg = 1'b0, stop = 1'b0;
    logic expire;
    logic [1:0] state;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    wdw_window_core #(.TICKS_PER_MS(TPM), .MIN_PULSE_TICKS(MINP)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .trig_i(trig),
        .long_sel_i(lsel), .close_sel_i(csel), .open_sel_i(osel),
        .lock_i(lock), .dis_ctrl_i(dctl), .dis_pin_i(dpin),
        .cfg_wr_i(cfg), .stop_i(stop), .expire_o(expire), .state_o(state));

    function automatic int bl(logic [1:0] c);
        return (c == 0 ? 200 : c == 1 ? 600 : c == 2 ? 2000 : 5000) * TPM;
    endfunction
    function automatic int bc(logic [1:0] c);
        return (c == 0 ? 10 : c == 1 ? 20 : c == 2 ? 50 : 100) * TPM;
    endfunction
    function automatic int bo(logic [1:0] c);
        return (c == 0 ? 20 : c == 1 ? 100 : c == 2 ? 200 : 600) * TPM;
    endfunction

    // reference model
    logic m_s1, m_s2, m_exp;
    int m_w, m_state, m_rem;
    logic [1:0] m_hl, m_hc, m_ho;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_exp = 0; m_w = 0; m_state = 0; m_rem = 0;
            m_hl = 0; m_hc = 0; m_ho = 0;
        end else begin
            automatic bit en = lock || !(dctl && dpin);
            automatic logic [1:0] el = lock ? m_hl : lsel;
            automatic logic [1:0] ec = lock ? m_hc : csel;
            automatic logic [1:0] eo = lock ? m_ho : osel;
            automatic bit tok = m_s2 && tick && (m_w == MINP - 1);
            automatic int nw = !m_s2 ? 0 : ((tick && m_w < MINP) ? m_w + 1 : m_w);
            automatic int ns = m_state, nr = m_rem;
            automatic bit nx = 0;
            if (!en) begin ns = 0; nr = 0; end
            else if (m_state == 0) begin ns = 1; nr = bl(el); end
            else if (cfg && !stop && !lock) begin ns = 1; nr = bl(el); end
            else if (tok) begin
                if (m_state == 2) begin nx = 1; ns = 1; nr = bl(el); end
                else begin ns = 2; nr = bc(ec); end
            end else if (tick) begin
                if (m_rem <= 1) begin
                    if (m_state == 2) begin ns = 3; nr = bo(eo); end
                    else begin nx = 1; ns = 1; nr = bl(el); end
                end else nr = m_rem - 1;
            end
            m_s2 = m_s1; m_s1 = trig; m_w = nw;
            m_state = ns; m_rem = nr; m_exp = nx;
            if (!lock) begin m_hl = lsel; m_hc = csel; m_ho = osel; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(state == 2'(m_state), {cur_req, " model state"}, state, m_state);
            chk(expire == m_exp, {cur_req, " model expire"}, expire, m_exp);
        end
    end

    task automatic pulse(input int w);
        @(negedge clk); trig = 1'b1;
        repeat (w) @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_state(input logic [1:0] s, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (state != s && n < 30000);
    endtask

    task automatic wait_expire(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!expire && n < 30000);
    endtask

    task automatic measure_close(output int n);
        int dummy;
        fork pulse(MINP + 2); join_none
        wait_state(2'd2, dummy);
        wait_state(2'd3, n);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int n, d;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        chk(state == 2'd0, "R1 reset state", state, 0);
        chk(expire == 1'b0, "R1 reset expire", expire, 0);
        rst_n = 1'b1;
        cur_req = "R2";
        wait_state(2'd1, n);
        chk(n == 1, "R2 long entry delay", n, 1);
        wait_expire(n);
        chk(n == bl(0), "R2 long code0 length", n, bl(0));
        chk(state == 2'd1, "R12 expire in long", state, 1);
        @(negedge clk);
        chk(expire == 1'b0, "R12 single cycle expire", expire, 0);
        // R8 restart with longer code
        cur_req = "R8";
        lsel = 2'd1; cfg = 1'b1;
        @(negedge clk); cfg = 1'b0;
        wait_expire(n);
        chk(n == bl(1), "R8 restart with code1 length R2", n, bl(1));
        lsel = 2'd0;
        // R6 short pulse
        cur_req = "R6";
        pulse(MINP - 1);
        repeat (6) @(negedge clk);
        chk(state == 2'd1, "R6 short pulse ignored", state, 1);
        // R4 / R3 / R7
        cur_req = "R4";
        measure_close(n);
        chk(n == bc(0), "R3 R4 close code0 length", n, bc(0));
        cur_req = "R7";
        wait_expire(n);
        chk(n == bo(0), "R7 open code0 expiry", n, bo(0));
        cur_req = "R3";
        csel = 2'd3; osel = 2'd2;
        measure_close(n);
        chk(n == bc(3), "R3 close code3 length", n, bc(3));
        wait_expire(n);
        chk(n == bo(2), "R3 open code2 length", n, bo(2));
        // R5 early trigger
        cur_req = "R5";
        fork pulse(MINP + 2); join_none
        wait_state(2'd2, d);
        repeat (20) @(negedge clk);
        fork pulse(MINP + 2); join_none
        wait_expire(n);
        chk(n <= MINP + 6, "R5 trigger in close expires", n, MINP + 6);
        chk(state == 2'd1, "R5 back to long", state, 1);
        // R11 code sampled at window start
        cur_req = "R11";
        fork pulse(MINP + 2); join_none
        wait_state(2'd2, d);
        csel = 2'd0;
        wait_state(2'd3, n);
        chk(n == bc(3), "R11 change mid close no effect", n, bc(3));
        measure_close(n);
        chk(n == bc(0), "R11 new code next close", n, bc(0));
        // R8 stop mode
        cur_req = "R8";
        fork pulse(MINP + 2); join_none
        wait_state(2'd2, d);
        stop = 1'b1; cfg = 1'b1;
        @(negedge clk); cfg = 1'b0; stop = 1'b0;
        chk(state == 2'd2, "R8 write in stop ignored", state, 2);
        cfg = 1'b1;
        @(negedge clk); cfg = 1'b0;
        chk(state == 2'd1, "R8 write restarts long", state, 1);
        // R9 disable
        cur_req = "R9";
        dpin = 1'b1;
        repeat (2) @(negedge clk);
        chk(state == 2'd1, "R9 pin ignored without ctrl", state, 1);
        dctl = 1'b1;
        @(negedge clk);
        chk(state == 2'd0, "R9 disabled", state, 0);
        repeat (3) @(negedge clk);
        dpin = 1'b0;
        @(negedge clk);
        chk(state == 2'd1, "R9 re-enable long", state, 1);
        // R10 lock
        cur_req = "R10";
        lock = 1'b1;
        @(negedge clk);
        dpin = 1'b1;
        repeat (2) @(negedge clk);
        chk(state == 2'd1, "R10 lock overrides disable", state, 1);
        csel = 2'd3;
        measure_close(n);
        chk(n == bc(0), "R10 codes frozen", n, bc(0));
        cfg = 1'b1;
        @(negedge clk); cfg = 1'b0;
        chk(state == 2'd3, "R10 write blocked by lock", state, 3);
        // random phase
        rst_n = 1'b0; lock = 1'b0; dpin = 1'b0; csel = 2'd0; osel = 2'd0;
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random";
        begin
            int left = 0;
            for (int i = 0; i < 40000; i++) begin
                @(negedge clk);
                tick = ($urandom % 2) == 0;
                if (left > 0) begin trig = 1'b1; left--; end
                else begin
                    trig = 1'b0;
                    if ($urandom % 120 == 0) left = 1 + int'($urandom % 6);
                end
                if ($urandom % 500 == 0) begin
                    lsel = 2'($urandom % 2); csel = 2'($urandom % 4); osel = 2'($urandom % 2);
                end
                cfg = ($urandom % 1500 == 0);
                if ($urandom % 700 == 0) stop = ~stop;
                if ($urandom % 900 == 0) dpin = ~dpin;
                dctl = 1'b1;
                if (i > 30000 && $urandom % 3000 == 0) lock = 1'b1;
            end
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule